// File: doc/BRIEF.md
# Streaming NAND Page ECC Accumulator

This block sits beside the byte path between a flash controller and a NAND device and builds a Hamming-style error code while data streams past. Every byte marked valid is folded into a running pair of 11-bit values for the 256-byte chunk it belongs to. Nothing is buffered. One value holds the parity terms and the other holds the complementary parity terms. A page of 256 bytes uses a single chunk. A page of 512 bytes uses two chunks, and each chunk keeps its own result pair.

Software, or a sequencer, pulses the clear request before a page moves and again once the results have been collected. While a clear is in progress the busy flag reads 1, the results read zero and incoming bytes are dropped. When the flag returns to 0 the accumulators are ready for a new page. For each chunk the block also presents a 22-bit packed code, ready to be split into three little-endian bytes for the spare area. Comparing codes and correcting data are left to the consumer.

Top module: `nand_ecc_accum`

## Requirements
- R1: After reset every result output and the packed codes read zero and `clr_busy` reads 0.
- R2: Bits [2:0] of a chunk's parity value are column terms: bit c is the XOR, over every accepted byte of the chunk, of the data bits whose bit index has bit c set.
- R3: Bits [10:3] of a chunk's parity value are row terms: bit 3+r is the XOR of the byte parities (XOR of all 8 bits) of the accepted bytes whose index within the chunk (0..255) has bit r set.
- R4: The complementary value uses the same layout as the parity value, with each bit taken over the positions whose corresponding index bit is clear.
- R5: Each packed code is {complementary value, parity value}: the parity value sits in bits [10:0] and the complementary value in bits [21:11].
- R6: With `page_512` high, accepted bytes 0..255 of the page feed chunk 0 and bytes 256..511 feed chunk 1.
- R7: With `page_512` low, only the first 256 accepted bytes count. Later bytes leave chunk 0 unchanged, and chunk 1 stays zero until the next clear.
- R8: A cycle with `clr_wr` high zeros both chunks and the byte count at that clock edge. `clr_busy` then reads 1 for CLR_CYCLES cycles (default 2) and then 0.
- R9: Bytes presented while `clr_busy` is 1 are ignored.
- R10: Cycles with `byte_vld` low leave all results unchanged, whatever `byte_in` carries.
- R11: With `page_512` high, bytes after the 512th are ignored until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Qualifies `byte_in` for the current cycle |
| byte_in | input | 8 | Data byte passing to or from the flash |
| page_512 | input | 1 | 1: two-chunk 512-byte page; 0: one-chunk 256-byte page |
| clr_wr | input | 1 | Clear request (write of 1 to the clear bit) |
| clr_busy | output | 1 | Reads 1 while a clear is in progress |
| res_par0 | output | 11 | Chunk 0 parity value |
| res_cpar0 | output | 11 | Chunk 0 complementary value |
| res_par1 | output | 11 | Chunk 1 parity value |
| res_cpar1 | output | 11 | Chunk 1 complementary value |
| code0 | output | 22 | Chunk 0 packed code |
| code1 | output | 22 | Chunk 1 packed code |

## Verification
The bench goes after the chunk boundary at byte 256. A design with an off-by-one index would push byte 255 into chunk 1, or byte 256 into chunk 0, and both codes would come out wrong. It also overfeeds both page sizes. A counter that does not stop would corrupt chunk 0, or leak bytes into chunk 1, on a 256-byte page. Bytes driven during the busy window and data toggling while `byte_vld` is low show up as nonzero results after a clear. Walking-one, all-ones and partial chunks expose any swap between the column and row fields, or between the parity and complementary halves.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

   // default geometry of the accumulator
   localparam int DEF_DATA_W      = 8;
   localparam int DEF_CHUNK_BYTES = 256;
   localparam int DEF_CLR_CYCLES  = 2;

   typedef enum logic [0:0] {
      CLR_IDLE = 1'b0,
      CLR_RUN  = 1'b1
   } clr_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/nand_ecc_byte_terms.sv
// Per-byte contribution to the parity and complementary parity values.
module nand_ecc_byte_terms #(
   parameter int DATA_W = nand_ecc_pkg::DEF_DATA_W,
   parameter int IDX_W  = 8
) (
   input  logic [DATA_W-1:0]                  data,
   input  logic [IDX_W-1:0]                   idx,
   output logic [IDX_W+$clog2(DATA_W)-1:0]    par_t,
   output logic [IDX_W+$clog2(DATA_W)-1:0]    cpar_t
);
   localparam int COL_W = $clog2(DATA_W);

   logic [COL_W-1:0] col_p;
   logic [COL_W-1:0] col_c;
   logic [IDX_W-1:0] row_p;
   logic [IDX_W-1:0] row_c;
   logic             byte_par;

   // column terms: split the bits of the byte by each bit of their index
   always_comb begin
      col_p = '0;
      col_c = '0;
      for (int c = 0; c < COL_W; c++) begin
         for (int b = 0; b < DATA_W; b++) begin
            if (((b >> c) & 1) == 1) col_p[c] = col_p[c] ^ data[b];
            else                     col_c[c] = col_c[c] ^ data[b];
         end
      end
   end

   assign byte_par = ^data;

   // row terms: byte parity routed by each bit of the byte index
   for (genvar r = 0; r < IDX_W; r++) begin : g_row
      assign row_p[r] = idx[r]  & byte_par;
      assign row_c[r] = ~idx[r] & byte_par;
   end

   assign par_t  = {row_p, col_p};
   assign cpar_t = {row_c, col_c};

endmodule

// File: rtl/nand_ecc_chunk_acc.sv
// Accumulator pair for one chunk.
module nand_ecc_chunk_acc #(
   parameter int ECC_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [ECC_W-1:0] par_t,
   input  logic [ECC_W-1:0] cpar_t,
   output logic [ECC_W-1:0] par_q,
   output logic [ECC_W-1:0] cpar_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q  <= '0;
         cpar_q <= '0;
      end else if (clr) begin
         par_q  <= '0;
         cpar_q <= '0;
      end else if (en) begin
         par_q  <= par_q ^ par_t;
         cpar_q <= cpar_q ^ cpar_t;
      end
   end
endmodule

// File: rtl/nand_ecc_clr_ctl.sv
// Clear sequencer: busy for CLR_CYCLES cycles after a clear request.
module nand_ecc_clr_ctl #(
   parameter int CLR_CYCLES = nand_ecc_pkg::DEF_CLR_CYCLES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_wr,
   output logic busy
);
   import nand_ecc_pkg::*;

   localparam int TW = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;

   if (CLR_CYCLES < 1) begin : g_bad_cycles
      $error("CLR_CYCLES must be at least 1");
   end

   clr_state_e      state;
   logic [TW-1:0]   tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CLR_IDLE;
         tmr   <= '0;
      end else if (clr_wr) begin
         state <= CLR_RUN;
         tmr   <= TW'(CLR_CYCLES - 1);
      end else if (state == CLR_RUN) begin
         if (tmr == '0) state <= CLR_IDLE;
         else           tmr   <= tmr - 1'b1;
      end
   end

   assign busy = (state == CLR_RUN);
endmodule

// File: rtl/nand_ecc_accum.sv
// Streaming ECC accumulator for 256- or 512-byte NAND pages.
module nand_ecc_accum #(
   parameter int DATA_W      = nand_ecc_pkg::DEF_DATA_W,
   parameter int CHUNK_BYTES = nand_ecc_pkg::DEF_CHUNK_BYTES,
   parameter int CLR_CYCLES  = nand_ecc_pkg::DEF_CLR_CYCLES
) (
   input  logic                                                   clk,
   input  logic                                                   rst_n,
   input  logic                                                   byte_vld,
   input  logic [DATA_W-1:0]                                      byte_in,
   input  logic                                                   page_512,
   input  logic                                                   clr_wr,
   output logic                                                   clr_busy,
   output logic [$clog2(CHUNK_BYTES)+$clog2(DATA_W)-1:0]          res_par0,
   output logic [$clog2(CHUNK_BYTES)+$clog2(DATA_W)-1:0]          res_cpar0,
   output logic [$clog2(CHUNK_BYTES)+$clog2(DATA_W)-1:0]          res_par1,
   output logic [$clog2(CHUNK_BYTES)+$clog2(DATA_W)-1:0]          res_cpar1,
   output logic [2*($clog2(CHUNK_BYTES)+$clog2(DATA_W))-1:0]      code0,
   output logic [2*($clog2(CHUNK_BYTES)+$clog2(DATA_W))-1:0]      code1
);
   import nand_ecc_pkg::*;

   localparam int NUM_CHUNKS = 2;
   localparam int IDX_W      = $clog2(CHUNK_BYTES);
   localparam int COL_W      = $clog2(DATA_W);
   localparam int ECC_W      = IDX_W + COL_W;
   localparam int CNT_W      = $clog2(CHUNK_BYTES * NUM_CHUNKS) + 1;
   localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(CHUNK_BYTES);
   localparam logic [CNT_W-1:0] LIM_TWO = CNT_W'(CHUNK_BYTES * NUM_CHUNKS);

   if (!is_pow2(DATA_W) || DATA_W < 2) begin : g_bad_dw
      $error("DATA_W must be a power of two, at least 2");
   end
   if (!is_pow2(CHUNK_BYTES) || CHUNK_BYTES < 2) begin : g_bad_cb
      $error("CHUNK_BYTES must be a power of two, at least 2");
   end

   logic [CNT_W-1:0]  byte_cnt;
   logic [CNT_W-1:0]  limit;
   logic              accept;
   logic              chunk_sel;
   logic [IDX_W-1:0]  idx;
   logic [ECC_W-1:0]  par_t;
   logic [ECC_W-1:0]  cpar_t;
   logic [ECC_W-1:0]  par_q  [NUM_CHUNKS];
   logic [ECC_W-1:0]  cpar_q [NUM_CHUNKS];

   nand_ecc_clr_ctl #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_wr (clr_wr),
      .busy   (clr_busy)
   );

   assign limit     = page_512 ? LIM_TWO : LIM_ONE;
   assign accept    = byte_vld & ~clr_busy & ~clr_wr & (byte_cnt < limit);
   assign chunk_sel = byte_cnt[IDX_W];
   assign idx       = byte_cnt[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      byte_cnt <= '0;
      else if (clr_wr) byte_cnt <= '0;
      else if (accept) byte_cnt <= byte_cnt + 1'b1;
   end

   nand_ecc_byte_terms #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_terms (
      .data   (byte_in),
      .idx    (idx),
      .par_t  (par_t),
      .cpar_t (cpar_t)
   );

   for (genvar ch = 0; ch < NUM_CHUNKS; ch++) begin : g_chunk
      logic en;
      assign en = accept & (chunk_sel == ch[0]);
      nand_ecc_chunk_acc #(.ECC_W(ECC_W)) u_acc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr_wr),
         .en     (en),
         .par_t  (par_t),
         .cpar_t (cpar_t),
         .par_q  (par_q[ch]),
         .cpar_q (cpar_q[ch])
      );
   end

   assign res_par0  = par_q[0];
   assign res_cpar0 = cpar_q[0];
   assign res_par1  = par_q[1];
   assign res_cpar1 = cpar_q[1];
   assign code0     = {cpar_q[0], par_q[0]};
   assign code1     = {cpar_q[1], par_q[1]};

endmodule

// File: rtl/nand_ecc_accum_chk.sv
module nand_ecc_accum_chk #(
   parameter int ECC_W = 11,
   parameter int CNT_W = 10,
   parameter int CHUNK_BYTES = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_vld,
   input logic             page_512,
   input logic             clr_wr,
   input logic             clr_busy,
   input logic [ECC_W-1:0] res_par0,
   input logic [ECC_W-1:0] res_cpar0,
   input logic [ECC_W-1:0] res_par1,
   input logic [ECC_W-1:0] res_cpar1,
   input logic [CNT_W-1:0] byte_cnt
);
   logic all_zero;
   assign all_zero = (res_par0 == '0) && (res_cpar0 == '0) &&
                     (res_par1 == '0) && (res_cpar1 == '0);

   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> all_zero && (byte_cnt == '0)); // R8
   AST_CLR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> clr_busy); // R8
   AST_BUSY_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy |-> all_zero && (byte_cnt == '0)); // R9
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld && !clr_wr) |=> ($stable(res_par0) && $stable(res_cpar0) &&
                                  $stable(res_par1) && $stable(res_cpar1))); // R10
   AST_SMALL_PAGE_CHUNK1: assert property (@(posedge clk) disable iff (!rst_n)
      (!page_512 && !clr_wr) |=> ($stable(res_par1) && $stable(res_cpar1))); // R7
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= CNT_W'(2 * CHUNK_BYTES)); // R11
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((byte_cnt == $past(byte_cnt)) ||
                   (byte_cnt == $past(byte_cnt) + 1'b1))); // R6
endmodule

bind nand_ecc_accum nand_ecc_accum_chk #(
   .ECC_W(ECC_W), .CNT_W(CNT_W), .CHUNK_BYTES(CHUNK_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .byte_vld  (byte_vld),
   .page_512  (page_512),
   .clr_wr    (clr_wr),
   .clr_busy  (clr_busy),
   .res_par0  (res_par0),
   .res_cpar0 (res_cpar0),
   .res_par1  (res_par1),
   .res_cpar1 (res_cpar1),
   .byte_cnt  (byte_cnt)
);

// File: tb/nand_ecc_accum_tb.sv
`timescale 1ns/1ps
module nand_ecc_accum_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_in = '0;
   logic        page_512 = 1'b0;
   logic        clr_wr = 1'b0;
   logic        clr_busy;
   logic [10:0] res_par0, res_cpar0, res_par1, res_cpar1;
   logic [21:0] code0, code1;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [7:0] pg [0:511];
   int model_cnt = 0;

   always #2 clk = ~clk;

   nand_ecc_accum u_dut (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
      .page_512(page_512), .clr_wr(clr_wr), .clr_busy(clr_busy),
      .res_par0(res_par0), .res_cpar0(res_cpar0),
      .res_par1(res_par1), .res_cpar1(res_cpar1),
      .code0(code0), .code1(code1)
   );

   // reference: {complementary, parity} for n bytes starting at base
   function automatic logic [21:0] ref_code(input int base, input int n);
      logic [10:0] p = '0;
      logic [10:0] q = '0;
      for (int i = 0; i < n; i++) begin
         logic [7:0] d = pg[base + i];
         for (int b = 0; b < 8; b++)
            for (int c = 0; c < 3; c++)
               if (((b >> c) & 1) == 1) p[c] ^= d[b]; else q[c] ^= d[b];
         for (int r = 0; r < 8; r++)
            if (((i >> r) & 1) == 1) p[3+r] ^= ^d; else q[3+r] ^= ^d;
      end
      return {q, p};
   endfunction

   task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      int n0 = (model_cnt > 256) ? 256 : model_cnt;
      int n1 = (model_cnt > 256) ? model_cnt - 256 : 0;
      logic [21:0] e0 = ref_code(0, n0);
      logic [21:0] e1 = ref_code(256, n1);
      check({req, " R2 col0"},  {19'd0, res_par0[2:0]},  {19'd0, e0[2:0]});
      check({req, " R3 row0"},  {14'd0, res_par0[10:3]}, {14'd0, e0[10:3]});
      check({req, " R4 cpar0"}, {11'd0, res_cpar0},      {11'd0, e0[21:11]});
      check({req, " R5 code0"}, code0, e0);
      check({req, " R6 code1"}, code1, e1);
      check({req, " R4 cpar1"}, {11'd0, res_cpar1},      {11'd0, e1[21:11]});
   endtask

   task automatic do_clear();
      @(negedge clk) clr_wr = 1'b1;
      @(negedge clk) clr_wr = 1'b0;
      check("R8 busy after clear", {21'd0, clr_busy}, 22'd1);
      check("R8 zero after clear", code0 | code1, 22'd0);
      for (int k = 0; k < 20 && clr_busy; k++) @(negedge clk);
      check("R8 busy released", {21'd0, clr_busy}, 22'd0);
      model_cnt = 0;
   endtask

   // pattern: 0 random, 1 all ones, 2 walking one, 3 zero
   task automatic stream(input int n, input int gap_pct, input int pattern);
      int sent = 0;
      int lim = page_512 ? 512 : 256;
      while (sent < n) begin
         @(negedge clk);
         if (int'($urandom % 100) < gap_pct) begin
            byte_vld = 1'b0;
            byte_in  = 8'($urandom);
         end else begin
            byte_vld = 1'b1;
            case (pattern)
               1: byte_in = 8'hFF;
               2: byte_in = 8'(1 << (sent % 8));
               3: byte_in = 8'h00;
               default: byte_in = 8'($urandom);
            endcase
            if (model_cnt < lim) begin
               pg[model_cnt] = byte_in;
               model_cnt++;
            end
            sent++;
         end
      end
      @(negedge clk);
      byte_vld = 1'b0;
      byte_in  = 8'($urandom);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0ECC));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset code0", code0, 22'd0);
      check("R1 reset code1", code1, 22'd0);
      check("R1 reset busy", {21'd0, clr_busy}, 22'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // single byte at index 0 and partial chunk with walking ones
      do_clear();
      stream(1, 0, 2);
      check_all("single byte");
      stream(36, 30, 2);
      check_all("partial walking");

      // R10: gaps with toggling data
      for (int k = 0; k < 5; k++) begin
         @(negedge clk) byte_in = 8'($urandom);
      end
      check_all("R10 idle data");

      // small page, random with gaps, then overfeed (R7)
      page_512 = 1'b0;
      do_clear();
      stream(256, 25, 0);
      check_all("R2 R3 small page");
      stream(20, 0, 0);
      check_all("R7 overfeed small");
      check("R7 chunk1 zero", code1, 22'd0);

      // all ones small page
      do_clear();
      stream(256, 0, 1);
      check_all("all ones");

      // R9: bytes during busy window ignored
      @(negedge clk) clr_wr = 1'b1;
      @(negedge clk) begin clr_wr = 1'b0; byte_vld = 1'b1; byte_in = 8'hA5; end
      @(negedge clk) byte_in = 8'h3C;
      @(negedge clk) byte_vld = 1'b0;
      check("R9 busy bytes dropped", code0 | code1, 22'd0);
      check("R8 busy low after window", {21'd0, clr_busy}, 22'd0);
      model_cnt = 0;

      // large page random, several rounds (R6, R11)
      page_512 = 1'b1;
      for (int rnd = 0; rnd < 4; rnd++) begin
         do_clear();
         stream(512, (rnd * 15) % 50, 0);
         check_all("R6 large page");
         stream(9, 0, 0);
         check_all("R11 overfeed large");
      end

      // boundary: 257 bytes, only one in chunk 1
      do_clear();
      stream(257, 0, 2);
      check_all("R6 boundary 257");

      // zeros give zero
      do_clear();
      stream(300, 10, 3);
      check("R2 zeros", code0 | code1, 22'd0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule